// File: doc/BRIEF.md
# Two-Factor Response-Monitoring Watchdog

This block supervises a link partner that is expected to send valid frames at regular intervals. Whenever a frame is accepted upstream, a one-cycle restart pulse reloads the watchdog. If no restart arrives within the configured window, a sticky timeout flag is raised so that the surrounding logic can react.

The window length is the product of two 8-bit factors and a base time of either 10 ms or 1 ms. A prescaler derived from the clock-frequency parameter produces a 1 ms tick. A decade stage then optionally stretches that tick to 10 ms. Two nested down-counters, one for each factor, count out the period without a multiplier. A parameter load latches the enable bit, the base select and both factors, and restarts the count. Factors below their safe minimums are raised to those minimums. While monitoring is disabled, the watchdog never expires. The output `rem_view` shows the state of both nested counters.

Top module: `resp_watchdog`

## Requirements
- R1: With monitoring on, `timeout` rises exactly B·F1·F2·(CLK_HZ/1000) clock cycles after the restarting edge, where F1 and F2 are the loaded factors and B is the base in ms. It is low in every cycle before that.
- R2: `cfg_base_1ms`=1 at load selects a 1 ms base (B=1). `cfg_base_1ms`=0 selects a 10 ms base (B=10).
- R3: When the loaded `cfg_wd_on` is 0, `timeout` never rises, no matter how long the block runs.
- R4: On load, a factor-1 value below 2 becomes 2 and a factor-2 value below 1 becomes 1. The clamped values appear in `rem_view` right after the load.
- R5: A `frame_ok` pulse reloads the full period from the loaded factors and clears `timeout`.
- R6: Once set, `timeout` stays at 1 until a `frame_ok` pulse or a `cfg_load` pulse.
- R7: A `cfg_load` pulse clears `timeout` and restarts the count with the new parameters. When `cfg_load` and `frame_ok` come in the same cycle, the new parameters are used.
- R8: `rem_view` is {outer count in bits 15:8, inner count in bits 7:0}. After a restart it equals {F1, F2}. While `timeout` is set it is 0.
- R9: After reset, `timeout` is 0, monitoring is off and `rem_view` is {2, 1}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | One-cycle pulse that latches the four cfg_* inputs |
| cfg_wd_on | input | 1 | Monitoring enable, latched on load |
| cfg_base_1ms | input | 1 | Base select: 1 = 1 ms, 0 = 10 ms |
| cfg_fact1 | input | FW | Outer factor, minimum 2 |
| cfg_fact2 | input | FW | Inner factor, minimum 1 |
| frame_ok | input | 1 | One-cycle restart pulse for each valid frame |
| timeout | output | 1 | Sticky expiry flag |
| rem_view | output | 2*FW | Remaining {outer, inner} counts |

## Verification
The hardest case is proving the exact expiry cycle across all three counter stages together: prescaler wrap, decade wrap and both factor wraps. The bench builds the clock parameter down to four cycles per millisecond. This makes the 10 ms path finish in a few hundred cycles. It then checks the flag one cycle before and at the computed edge. The clamp case and the load-versus-restart tie are reached only through one load pulse with zero factors, or with both pulses in the same cycle. Their results are read back through `rem_view` immediately afterwards.

// File: rtl/resp_watchdog.sv
`timescale 1ns/1ps
module resp_watchdog #(
  parameter int CLK_HZ = 125_000_000,
  parameter int FW     = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic          cfg_wd_on,
  input  logic          cfg_base_1ms,
  input  logic [FW-1:0] cfg_fact1,
  input  logic [FW-1:0] cfg_fact2,
  input  logic          frame_ok,
  output logic          timeout,
  output logic [2*FW-1:0] rem_view
);
  localparam int CPM = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int PW  = (CPM > 1) ? $clog2(CPM) : 1;
  localparam logic [FW-1:0] F1_MIN = FW'(2);
  localparam logic [FW-1:0] F2_MIN = FW'(1);
  localparam logic [PW-1:0] PRE_TOP = PW'(CPM - 1);

  logic          mon_on, base_10;
  logic [FW-1:0] f1_q, f2_q, c1, c2;
  logic [PW-1:0] pres;
  logic [3:0]    dec;

  wire [FW-1:0] f1_in = (cfg_fact1 < F1_MIN) ? F1_MIN : cfg_fact1;
  wire [FW-1:0] f2_in = (cfg_fact2 < F2_MIN) ? F2_MIN : cfg_fact2;
  wire run       = mon_on & ~timeout;
  wire ms_tick   = run & (pres == PRE_TOP);
  wire unit_tick = ms_tick & (~base_10 | (dec == 4'd9));

  assign rem_view = {c1, c2};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mon_on  <= 1'b0;
      base_10 <= 1'b1;
      f1_q    <= F1_MIN;
      f2_q    <= F2_MIN;
    end else if (cfg_load) begin
      mon_on  <= cfg_wd_on;
      base_10 <= ~cfg_base_1ms;
      f1_q    <= f1_in;
      f2_q    <= f2_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pres    <= '0;
      dec     <= '0;
      c1      <= F1_MIN;
      c2      <= F2_MIN;
      timeout <= 1'b0;
    end else if (cfg_load) begin
      pres    <= '0;
      dec     <= '0;
      c1      <= f1_in;
      c2      <= f2_in;
      timeout <= 1'b0;
    end else if (frame_ok) begin
      pres    <= '0;
      dec     <= '0;
      c1      <= f1_q;
      c2      <= f2_q;
      timeout <= 1'b0;
    end else if (run) begin
      pres <= ms_tick ? '0 : pres + 1'b1;
      if (ms_tick)
        dec <= unit_tick ? 4'd0 : dec + 4'd1;
      if (unit_tick) begin
        if (c2 > F2_MIN) begin
          c2 <= c2 - 1'b1;
        end else if (c1 > F2_MIN) begin
          c1 <= c1 - 1'b1;
          c2 <= f2_q;
        end else begin
          c1      <= '0;
          c2      <= '0;
          timeout <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/resp_watchdog_chk.sv
`timescale 1ns/1ps
module resp_watchdog_chk #(
  parameter int FW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_load,
  input logic            frame_ok,
  input logic            mon_on,
  input logic            timeout,
  input logic [2*FW-1:0] rem_view
);
  localparam logic [2*FW-1:0] LAST_VIEW = {FW'(1), FW'(1)};

  p_expire_at_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $past(rem_view) == LAST_VIEW);

  p_off_never_expires_r3: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> mon_on);

  p_clamped_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> (rem_view[2*FW-1:FW] >= FW'(2)) && (rem_view[FW-1:0] >= FW'(1)));

  p_restart_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !timeout);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout && !frame_ok && !cfg_load |=> timeout);

  p_load_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> !timeout);

  p_view_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> rem_view == '0);
endmodule

bind resp_watchdog resp_watchdog_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .frame_ok(frame_ok),
  .mon_on(mon_on), .timeout(timeout), .rem_view(rem_view)
);

// File: tb/test_resp_watchdog.sv
`timescale 1ns/1ps
module test_resp_watchdog;
  localparam int CLK_HZ = 4000;
  localparam int CPM    = CLK_HZ / 1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_load = 1'b0, cfg_wd_on = 1'b0, cfg_base_1ms = 1'b0, frame_ok = 1'b0;
  logic [7:0] cfg_fact1 = '0, cfg_fact2 = '0;
  logic timeout;
  logic [15:0] rem_view;
  int checks = 0, failures = 0;

  always #4 clk = ~clk;

  resp_watchdog #(.CLK_HZ(CLK_HZ), .FW(8)) i_resp_watchdog (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_wd_on(cfg_wd_on),
    .cfg_base_1ms(cfg_base_1ms), .cfg_fact1(cfg_fact1), .cfg_fact2(cfg_fact2),
    .frame_ok(frame_ok), .timeout(timeout), .rem_view(rem_view)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load(input logic on, input logic b1, input int f1, input int f2, input logic with_frame);
    @(negedge clk);
    cfg_wd_on = on; cfg_base_1ms = b1; cfg_fact1 = 8'(f1); cfg_fact2 = 8'(f2);
    cfg_load = 1'b1; frame_ok = with_frame;
    @(negedge clk);
    cfg_load = 1'b0; frame_ok = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk); frame_ok = 1'b1;
    @(negedge clk); frame_ok = 1'b0;
  endtask

  task automatic expect_expiry(input int n, input string req);
    repeat (n - 1) @(negedge clk);
    check({req, " low before end"}, int'(timeout), 0);
    @(negedge clk);
    check({req, " high at end"}, int'(timeout), 1);
  endtask

  task automatic t_reset();
    check("R9 timeout", int'(timeout), 0);
    check("R9 view", int'(rem_view), 16'h0201);
    repeat (200) @(negedge clk);
    check("R9 monitoring off", int'(timeout), 0);
  endtask

  task automatic t_period_1ms();
    load(1'b1, 1'b1, 2, 3, 1'b0);
    check("R8 view after load", int'(rem_view), 16'h0203);
    expect_expiry(CPM * 1 * 2 * 3, "R1 R2 1ms");
  endtask

  task automatic t_period_10ms();
    load(1'b1, 1'b0, 3, 2, 1'b0);
    expect_expiry(CPM * 10 * 3 * 2, "R1 R2 10ms");
  endtask

  task automatic t_clamp();
    load(1'b1, 1'b1, 0, 0, 1'b0);
    check("R4 clamped view", int'(rem_view), 16'h0201);
    expect_expiry(CPM * 2 * 1, "R4 clamped period");
    load(1'b1, 1'b1, 1, 5, 1'b0);
    check("R4 f1=1 clamped", int'(rem_view), 16'h0205);
  endtask

  task automatic t_disabled();
    load(1'b0, 1'b1, 2, 1, 1'b0);
    repeat (3000) @(negedge clk);
    check("R3 never expires", int'(timeout), 0);
    check("R3 count held", int'(rem_view), 16'h0201);
  endtask

  task automatic t_restart_mid();
    load(1'b1, 1'b1, 2, 3, 1'b0);
    repeat (20) @(negedge clk);
    check("R5 not yet", int'(timeout), 0);
    restart();
    check("R5 reload view", int'(rem_view), 16'h0203);
    expect_expiry(CPM * 6, "R5 full period");
  endtask

  task automatic t_sticky();
    repeat (100) @(negedge clk);
    check("R6 sticky", int'(timeout), 1);
    check("R8 view zero", int'(rem_view), 0);
    restart();
    check("R5 clears", int'(timeout), 0);
    expect_expiry(CPM * 6, "R5 second window");
  endtask

  task automatic t_load_clears();
    load(1'b1, 1'b1, 4, 2, 1'b0);
    check("R7 clears", int'(timeout), 0);
    check("R7 new view", int'(rem_view), 16'h0402);
    expect_expiry(CPM * 8, "R7 new period");
  endtask

  task automatic t_priority();
    load(1'b1, 1'b1, 5, 7, 1'b1);
    check("R7 load wins", int'(rem_view), 16'h0507);
    check("R7 tie clears", int'(timeout), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_period_1ms();
    t_period_10ms();
    t_clamp();
    t_disabled();
    t_restart_mid();
    t_sticky();
    t_load_clears();
    t_priority();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule